// File: doc/BRIEF.md
# I2C Bus Condition Status Monitor

This block listens passively to the clock and data lines of a two-wire I2C bus and reports what it sees as a small set of status flags. It recognises start conditions, stop conditions and the acknowledge slot at the end of each byte. It also keeps a bus-busy flag and shows which clock of the current byte the bus has reached. It never drives the bus.

Each flag has its own set and clear rules. These rules are tied to particular clock edges inside a byte and to two control inputs: an interface enable and a one-cycle release request. While the interface is disabled, every flag reads zero. A two-bit configuration register holds a reservation-enable bit and a start-enable bit. The start-enable bit picks the bus-busy value loaded when the interface is switched on. The register accepts writes only while the interface is off.

Both bus lines pass through a two-flop synchronizer before edge detection. A line change therefore reaches the flags on the third rising edge of the system clock after it.

Top module: `i2c_cond_monitor`

## Requirements
- R1: SDA falling while SCL is high (a start condition) sets `start_seen` and `bus_busy` and returns `bit_pos` to 0, including when it happens in the middle of a byte.
- R2: SDA rising while SCL is high (a stop condition) sets `stop_seen` and clears `start_seen`, `ack_seen`, `bus_busy` and `bit_pos`.
- R3: `ack_seen` is set only if SDA is low at the rising edge of SCL that makes `bit_pos` equal 9. A high SDA at that edge leaves `ack_seen` at 0.
- R4: `ack_seen` clears at the rising edge of SCL that starts the next byte, that is, the edge that takes `bit_pos` from 9 to 1.
- R5: `start_seen` stays set through all nine clocks of the address byte. It clears at the first SCL rising edge of the byte after the address byte.
- R6: `stop_seen` is not cleared by a new start condition. It clears at the first SCL rising edge after a start condition (the edge that takes `bit_pos` from 0 to 1).
- R7: A `release_req` pulse clears `ack_seen` and `start_seen` and leaves `stop_seen` and `bus_busy` unchanged.
- R8: While `mon_en` is 0, `ack_seen`, `start_seen`, `stop_seen`, `bus_busy` and `bit_pos` are all 0, and bus activity does not change them.
- R9: On the cycle after `mon_en` rises, `bus_busy` equals the inverse of the start-enable bit: 0 when start-enable is 1, and 1 when it is 0.
- R10: `cfg_q` resets to 0 and holds start-enable in bit 0 and reservation-enable in bit 1. A `cfg_wr` loads `cfg_wdata` only while `mon_en` is 0 and is ignored while `mon_en` is 1.
- R11: After a start condition, `bit_pos` is 0. Each SCL rising edge advances it by one up to 9, and the edge after 9 gives 1. It never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| mon_en | input | 1 | Interface enable |
| release_req | input | 1 | One-cycle request to leave the current transfer |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Configuration write data: bit 0 start-enable, bit 1 reservation-enable |
| cfg_q | output | 2 | Configuration register contents |
| ack_seen | output | 1 | Acknowledge detected in the ninth clock |
| start_seen | output | 1 | Start condition detected; address byte in progress |
| stop_seen | output | 1 | Stop condition detected; bus released |
| bus_busy | output | 1 | Bus occupied |
| bit_pos | output | 4 | Clock position in the current byte, 0 to 9 |

## Verification
The bound checker watches a set of rules on every cycle:
- every flag is zero while the interface is off;
- the configuration stays frozen while the interface is on;
- `bit_pos` never leaves 0 to 9 and only steps by one, to 1 or to 0;
- a new acknowledge appears only at position 9;
- a new start flag comes with bus-busy set and position 0;
- a new stop flag comes with busy, start and acknowledge cleared;
- the stop flag drops only at position 1 or on disable.

Only the bench scenarios can show the rest: that the right flag clears at the right byte boundary, the acknowledge against not-acknowledge decision, that release spares the stop flag, the busy value loaded at enable for each start-enable setting, and that writes are ignored while enabled.

// File: rtl/i2c_mon_pkg.sv
// Package: shared types and constants for the I2C bus condition monitor.
// Assumes: one event record per system clock, produced from synchronized lines.
package i2c_mon_pkg;

    // Configuration register field positions
    localparam int unsigned CFG_W        = 2;
    localparam int unsigned CFG_START_EN = 0;
    localparam int unsigned CFG_RESV_EN  = 1;

    // Line events decoded from the synchronized bus lines
    typedef struct packed {
        logic scl_rise;   // SCL low-to-high
        logic start_cond; // SDA falls while SCL stays high
        logic stop_cond;  // SDA rises while SCL stays high
        logic sda_lvl;    // current synchronized SDA level
    } bus_evt_t;

    // Byte-slot events derived from the bit position
    typedef struct packed {
        logic addr_first; // first SCL rise after a start condition
        logic byte_first; // first SCL rise of a byte following a complete byte
        logic ninth_rise; // SCL rise that completes the acknowledge clock
    } slot_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: multi-stage synchronizer for a group of asynchronous lines.
// Assumes: lines idle high, so the stages reset to 1; STAGES >= 2.
module i2c_line_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] shreg;

        // Shift the raw line through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shreg <= '1;
            end else begin
                shreg <= {shreg[STAGES-2:0], din[g]};
            end
        end

        assign dout[g] = shreg[STAGES-1];
    end

endmodule

// File: rtl/i2c_bus_event.sv
// Module: decodes SCL rising edges and start/stop conditions from the
// synchronized lines by comparing them with their previous-cycle values.
// Assumes: SCL and SDA never change in the same synchronized cycle.
module i2c_bus_event
    import i2c_mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);

    logic scl_p;
    logic sda_p;

    // Keep the previous-cycle levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Classify the transitions of this cycle
    always_comb begin
        evt.scl_rise   = scl_s & ~scl_p;
        evt.start_cond = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop_cond  = scl_s & scl_p & ~sda_p & sda_s;
        evt.sda_lvl    = sda_s;
    end

endmodule

// File: rtl/i2c_bit_tracker.sv
// Module: tracks the clock position inside the current byte (0 after a start,
// 1..LAST per SCL rise, wrapping to 1) and flags the byte-boundary edges.
// Assumes: counting only happens inside a frame opened by a start condition.
module i2c_bit_tracker
    import i2c_mon_pkg::*;
#(
    parameter int unsigned LAST  = 9,
    parameter int unsigned POS_W = $clog2(LAST + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  bus_evt_t         evt,
    output logic [POS_W-1:0] pos,
    output slot_evt_t        slot
);

    localparam logic [POS_W-1:0] POS_IDLE = '0;
    localparam logic [POS_W-1:0] POS_ONE  = POS_W'(1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(LAST);
    localparam logic [POS_W-1:0] POS_ACK  = POS_W'(LAST - 1);

    logic in_frame;
    logic rise_in_frame;

    assign rise_in_frame = en & in_frame & evt.scl_rise;

    // Frame membership and bit position
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            in_frame <= 1'b0;
            pos      <= POS_IDLE;
        end else if (evt.stop_cond) begin
            in_frame <= 1'b0;
            pos      <= POS_IDLE;
        end else if (evt.start_cond) begin
            in_frame <= 1'b1;
            pos      <= POS_IDLE;
        end else if (rise_in_frame) begin
            if (pos == POS_IDLE || pos == POS_LAST) begin
                pos <= POS_ONE;
            end else begin
                pos <= pos + POS_ONE;
            end
        end
    end

    // Boundary edges seen by the flag logic
    always_comb begin
        slot.addr_first = rise_in_frame & (pos == POS_IDLE);
        slot.byte_first = rise_in_frame & (pos == POS_LAST);
        slot.ninth_rise = rise_in_frame & (pos == POS_ACK);
    end

endmodule

// File: rtl/i2c_cfg_reg.sv
// Module: configuration register with reservation-enable and start-enable bits,
// writable only while the interface is disabled.
// Assumes: the write strobe is one system-clock cycle wide.
module i2c_cfg_reg
    import i2c_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] q
);

    // Load on a write while the interface is off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr && !en) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/i2c_status_flags.sv
// Module: acknowledge, start, stop and bus-busy flags with their individual
// set and clear rules.
// Assumes: line events and slot events never fall in the same cycle as a
// start or stop condition (SCL is high and stable at a condition).
module i2c_status_flags
    import i2c_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      release_req,
    input  logic      start_en,
    input  bus_evt_t  evt,
    input  slot_evt_t slot,
    output logic      ack_seen,
    output logic      start_seen,
    output logic      stop_seen,
    output logic      bus_busy
);

    logic en_q;
    logic en_rise;
    logic clr_ack;
    logic clr_start;

    assign en_rise   = en & ~en_q;
    assign clr_ack   = evt.stop_cond | slot.byte_first | release_req;
    assign clr_start = evt.stop_cond | slot.byte_first | release_req;

    // Remember the previous enable level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en;
        end
    end

    // Acknowledge flag
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ack_seen <= 1'b0;
        end else if (clr_ack) begin
            ack_seen <= 1'b0;
        end else if (slot.ninth_rise && !evt.sda_lvl) begin
            ack_seen <= 1'b1;
        end
    end

    // Start flag
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            start_seen <= 1'b0;
        end else if (evt.start_cond) begin
            start_seen <= 1'b1;
        end else if (clr_start) begin
            start_seen <= 1'b0;
        end
    end

    // Stop flag: a release request deliberately leaves it alone
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            stop_seen <= 1'b0;
        end else if (evt.stop_cond) begin
            stop_seen <= 1'b1;
        end else if (slot.addr_first) begin
            stop_seen <= 1'b0;
        end
    end

    // Bus-busy flag with its start-enable controlled initial value
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            bus_busy <= 1'b0;
        end else if (en_rise) begin
            bus_busy <= ~start_en;
        end else if (evt.start_cond) begin
            bus_busy <= 1'b1;
        end else if (evt.stop_cond) begin
            bus_busy <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_cond_monitor.sv
// Module: top of the I2C bus condition status monitor. Synchronizes the bus
// lines, decodes conditions, tracks the bit position and keeps the flags.
// Assumes: a passive observer; the bus is driven elsewhere.
module i2c_cond_monitor
    import i2c_mon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned CLK_PER_BYTE = 9,
    parameter int unsigned POS_W        = $clog2(CLK_PER_BYTE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             mon_en,
    input  logic             release_req,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic             ack_seen,
    output logic             start_seen,
    output logic             stop_seen,
    output logic             bus_busy,
    output logic [POS_W-1:0] bit_pos
);

    logic [1:0] lines_s;
    bus_evt_t   evt;
    slot_evt_t  slot;

    i2c_line_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sda_in, scl_in}),
        .dout  (lines_s)
    );

    i2c_bus_event u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[0]),
        .sda_s (lines_s[1]),
        .evt   (evt)
    );

    i2c_bit_tracker #(
        .LAST  (CLK_PER_BYTE),
        .POS_W (POS_W)
    ) u_trk (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mon_en),
        .evt   (evt),
        .pos   (bit_pos),
        .slot  (slot)
    );

    i2c_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mon_en),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    i2c_status_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (mon_en),
        .release_req (release_req),
        .start_en    (cfg_q[CFG_START_EN]),
        .evt         (evt),
        .slot        (slot),
        .ack_seen    (ack_seen),
        .start_seen  (start_seen),
        .stop_seen   (stop_seen),
        .bus_busy    (bus_busy)
    );

endmodule

// File: rtl/i2c_cond_monitor_chk.sv
// Module: cycle-by-cycle property checker for the condition monitor,
// attached to every instance of the top module through bind.
// Assumes: sampled on the same clock and reset as the monitor.
module i2c_cond_monitor_chk #(
    parameter int unsigned POS_W = 4,
    parameter int unsigned LAST  = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mon_en,
    input logic [1:0]       cfg_q,
    input logic             ack_seen,
    input logic             start_seen,
    input logic             stop_seen,
    input logic             bus_busy,
    input logic [POS_W-1:0] bit_pos
);

    a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> (!ack_seen && !start_seen && !stop_seen && !bus_busy && bit_pos == '0));

    a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        mon_en |=> $stable(cfg_q));

    a_r11_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        bit_pos <= POS_W'(LAST));

    a_r11_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_pos != $past(bit_pos)) |->
            (bit_pos == '0 || bit_pos == POS_W'(1) || bit_pos == $past(bit_pos) + POS_W'(1)));

    a_r3_ack_at_nine: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_seen) |-> bit_pos == POS_W'(LAST));

    a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_seen) |-> (bus_busy && bit_pos == '0));

    a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_seen) |-> (!bus_busy && !start_seen && !ack_seen));

    a_r6_stop_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_seen) |-> (bit_pos == POS_W'(1) || !$past(mon_en)));

endmodule

bind i2c_cond_monitor i2c_cond_monitor_chk #(
    .POS_W (POS_W),
    .LAST  (CLK_PER_BYTE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mon_en     (mon_en),
    .cfg_q      (cfg_q),
    .ack_seen   (ack_seen),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .bus_busy   (bus_busy),
    .bit_pos    (bit_pos)
);

// File: tb/i2c_cond_monitor_bench.sv
// Scoreboard bench: driver tasks move the bus lines, update a reference model
// built from the requirements and push expected snapshots; a monitor pops
// and compares them against the outputs.
module i2c_cond_monitor_bench;

    localparam int HOLD = 6;

    typedef struct packed {
        logic       ack;
        logic       start;
        logic       stop;
        logic       busy;
        logic [3:0] pos;
        logic [1:0] cfg;
    } snap_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_o = 1'b1;
    logic       sda_o = 1'b1;
    logic       mon_en = 1'b0;
    logic       release_req = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic [1:0] cfg_q;
    logic       ack_seen, start_seen, stop_seen, bus_busy;
    logic [3:0] bit_pos;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    snap_t exp_q[$];
    string tag_q[$];

    // reference model state
    logic       m_ack = 0, m_start = 0, m_stop = 0, m_busy = 0, m_frame = 0;
    logic [3:0] m_pos = 0;
    logic [1:0] m_cfg = 0;

    always #10 clk = ~clk;

    i2c_cond_monitor u_i2c_cond_monitor (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_o),
        .sda_in      (sda_o),
        .mon_en      (mon_en),
        .release_req (release_req),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .cfg_q       (cfg_q),
        .ack_seen    (ack_seen),
        .start_seen  (start_seen),
        .stop_seen   (stop_seen),
        .bus_busy    (bus_busy),
        .bit_pos     (bit_pos)
    );

    // monitor: compare each expected snapshot with the outputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            snap_t e;
            snap_t a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{ack_seen, start_seen, stop_seen, bus_busy, bit_pos, cfg_q};
            vectors++;
            if (a !== e) begin
                miscompares++;
                $display("FAIL %s: actual ack=%b start=%b stop=%b busy=%b pos=%0d cfg=%b, expected ack=%b start=%b stop=%b busy=%b pos=%0d cfg=%b",
                         t, a.ack, a.start, a.stop, a.busy, a.pos, a.cfg,
                         e.ack, e.start, e.stop, e.busy, e.pos, e.cfg);
            end
        end
    end

    task automatic chk(input string tag);
        exp_q.push_back('{m_ack, m_start, m_stop, m_busy, m_pos, m_cfg});
        tag_q.push_back(tag);
        repeat (2) @(negedge clk);
    endtask

    task automatic drive(input logic s, input logic d);
        @(negedge clk);
        scl_o = s;
        sda_o = d;
        repeat (HOLD) @(negedge clk);
    endtask

    // SCL low with data d, then SCL rise; model the rising edge
    task automatic clk_rise(input logic d);
        logic [3:0] old;
        drive(1'b0, d);
        drive(1'b1, d);
        if (mon_en && m_frame) begin
            old = m_pos;
            if (old == 0) m_stop = 0;
            if (old == 9) begin m_ack = 0; m_start = 0; end
            if (old == 8 && d == 1'b0) m_ack = 1;
            m_pos = (old == 0 || old == 9) ? 4'd1 : old + 4'd1;
        end
    endtask

    task automatic gen_start;
        drive(1'b1, 1'b0);
        if (mon_en) begin m_start = 1; m_busy = 1; m_pos = 0; m_frame = 1; end
    endtask

    task automatic gen_stop;
        drive(1'b1, 1'b1);
        if (mon_en) begin
            m_stop = 1; m_start = 0; m_ack = 0; m_busy = 0; m_pos = 0; m_frame = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] data, input logic ackbit, input string tag);
        for (int i = 7; i >= 0; i--) begin
            clk_rise(data[i]);
            chk(tag);
        end
        clk_rise(ackbit);
        chk(tag);
        drive(1'b0, ackbit);
    endtask

    task automatic pulse_release;
        @(negedge clk) release_req = 1'b1;
        @(negedge clk) release_req = 1'b0;
        repeat (HOLD) @(negedge clk);
        if (mon_en) begin m_ack = 0; m_start = 0; end
    endtask

    task automatic write_cfg(input logic [1:0] v);
        @(negedge clk) begin cfg_wr = 1'b1; cfg_wdata = v; end
        @(negedge clk) cfg_wr = 1'b0;
        repeat (2) @(negedge clk);
        if (!mon_en) m_cfg = v;
    endtask

    task automatic set_en(input logic v);
        @(negedge clk) mon_en = v;
        repeat (HOLD) @(negedge clk);
        if (v) m_busy = ~m_cfg[0];
        else begin
            m_ack = 0; m_start = 0; m_stop = 0; m_busy = 0; m_pos = 0; m_frame = 0;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual run still going, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // stimulus
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 reset state");

        // R10 write while disabled: start-enable = 1
        write_cfg(2'b01);
        chk("R10 write while disabled");
        // R9 enable with start-enable 1 loads busy 0
        set_en(1'b1);
        chk("R9 busy init with start-enable 1");
        // R10 write while enabled is ignored
        write_cfg(2'b10);
        chk("R10 write while enabled ignored");

        // R1 start
        gen_start;
        chk("R1 start sets start and busy");
        drive(1'b0, 1'b0);
        // R11 positions, R3 ack, R5 start held through address byte
        send_byte(8'hA4, 1'b0, "R11 R3 R5 address byte with ack");
        // R4 ack clear and R5 start clear at first clock of next byte
        clk_rise(1'b0);
        chk("R4 R5 first clock of data byte");
        drive(1'b0, 1'b0);
        for (int i = 0; i < 7; i++) begin
            clk_rise(i[0]);
            drive(1'b0, i[0]);
        end
        clk_rise(1'b1);
        chk("R3 not-acknowledge leaves ack clear");
        drive(1'b0, 1'b0);
        // R2 stop
        clk_rise(1'b0);
        gen_stop;
        chk("R2 stop condition");

        // R6 stop flag survives a new start, drops at first clock
        gen_start;
        chk("R6 stop kept after new start");
        drive(1'b0, 1'b1);
        clk_rise(1'b1);
        chk("R6 stop cleared at first clock");
        drive(1'b0, 1'b0);
        for (int i = 0; i < 7; i++) begin
            clk_rise(1'b0);
            drive(1'b0, 1'b0);
        end
        clk_rise(1'b0);
        chk("R3 ack on ninth clock");
        drive(1'b0, 1'b0);
        // R7 release clears ack
        pulse_release;
        chk("R7 release clears ack");
        clk_rise(1'b0);
        gen_stop;
        gen_start;
        chk("R7 setup stop and start both set");
        pulse_release;
        chk("R7 release clears start keeps stop and busy");
        drive(1'b0, 1'b0);

        // R1 R11 repeated start mid-byte
        clk_rise(1'b1);
        drive(1'b0, 1'b1);
        clk_rise(1'b0);
        drive(1'b0, 1'b1);
        clk_rise(1'b1);
        chk("R11 position before repeated start");
        gen_start;
        chk("R1 R11 repeated start resets position");
        drive(1'b0, 1'b0);

        // R8 disable clears and holds everything at zero
        set_en(1'b0);
        chk("R8 disable clears flags");
        drive(1'b1, 1'b1);
        gen_start;
        chk("R8 start ignored while disabled");
        drive(1'b1, 1'b1);

        // R10 then R9 with start-enable 0
        write_cfg(2'b10);
        chk("R10 reservation bit written while disabled");
        set_en(1'b1);
        chk("R9 busy init with start-enable 0");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule